// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor

This block adds or subtracts two signed operands of parameterised width in pure combinational logic. A single mode input selects the operation. When the mode is low the block adds. When it is high the block subtracts. Both operations share one ripple chain of full-adder cells. For subtraction, each bit of the second operand is inverted and the carry into the lowest stage is forced high. This forms the two's-complement negative without a second adder.

Three outputs are produced: the sum or difference, truncated to the operand width; the carry leaving the most significant stage; and one flag. The flag marks a signed result that has left the representable range in either direction. It is derived by comparing the carry that enters the top stage with the carry that leaves it. Callers that treat the operands as unsigned use the carry. Callers that treat them as signed use the flag.

Top module: `adder_subtractor`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (`op_a` + `op_b`) modulo 2^WIDTH.
- R2: With `sub_mode` = 1, `result` equals (`op_a` − `op_b`) modulo 2^WIDTH.
- R3: `carry_out` is the carry leaving bit WIDTH−1. When adding, it is 1 exactly when the unsigned sum reaches 2^WIDTH. When subtracting, the chain computes `op_a` + ~`op_b` + 1, so it is 1 exactly when `op_a` ≥ `op_b` as unsigned numbers.
- R4: `ovf` is 1 exactly when the true signed result lies outside −2^(WIDTH−1) … 2^(WIDTH−1)−1. This is the same as the carry into the top stage differing from the carry out of it.
- R5: Adding two non-negative operands whose true sum exceeds 2^(WIDTH−1)−1 sets `ovf`. For WIDTH=4, 7 + 7 yields `result` = 4'b1110 with `ovf` = 1.
- R6: Adding two negative operands whose true sum is below −2^(WIDTH−1) sets `ovf`. For WIDTH=4, (−7) + (−7) yields `result` = 4'b0010 with `ovf` = 1.
- R7: Adding operands of opposite sign never sets `ovf`. For WIDTH=4, 7 + (−8) yields `result` = 4'b1111 with `ovf` = 0.
- R8: Subtracting operands of equal sign never sets `ovf`. Subtracting an operand of the opposite sign sets `ovf` when the range is left. For WIDTH=4, (−8) − 1 yields 4'b0111 with `ovf` = 1, and 0 − (−8) yields 4'b1000 with `ovf` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand, two's complement |
| op_b | input | WIDTH | Second operand, two's complement |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Sum or difference, truncated to WIDTH bits |
| carry_out | output | 1 | Carry out of the most significant stage |
| ovf | output | 1 | Signed overflow or underflow flag |

## Verification
The bound checker evaluates every input change. It confirms the truncated sum or difference together with the carry, and it ties the flag to the operand and result signs. It also confirms that the flag stays clear for opposite-sign additions and for equal-sign subtractions. Only the bench's scenarios can show the named corner values, such as 7+7, (−7)+(−7), 7+(−8) and the two subtraction overflows at the negative limit. Only they can show that the full operand sweep in both modes agrees with a signed integer reference computed apart from the design.

// File: rtl/adsub_pkg.sv
package adsub_pkg;

    // Operation select encoding for the mode input
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } adsub_op_e;

endpackage

// File: rtl/adsub_fa.sv
module adsub_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    // One bit cell: parity sum and majority carry
    always_comb begin
        s_o = x_i ^ y_i ^ c_i;
        c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
    end

endmodule

// File: rtl/adsub_operand.sv
module adsub_operand #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] b_eff_o,
    output logic             cin_o
);

    import adsub_pkg::*;

    adsub_op_e op;

    always_comb op = adsub_op_e'(sub_i);

    // Conditional inversion: each bit passes through an XOR with the mode
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        always_comb b_eff_o[i] = b_i[i] ^ (op == OP_SUB);
    end

    // The +1 of the two's-complement negate enters as the chain's carry-in
    always_comb cin_o = (op == OP_SUB);

endmodule

// File: rtl/adsub_ripple.sv
module adsub_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_msb_in_o,
    output logic             c_msb_out_o
);

    localparam int NCARRY = WIDTH + 1;

    logic [NCARRY-1:0] carry;

    always_comb carry[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        adsub_fa u_fa (
            .x_i (a_i[i]),
            .y_i (b_i[i]),
            .c_i (carry[i]),
            .s_o (sum_o[i]),
            .c_o (carry[i+1])
        );
    end

    always_comb begin
        c_msb_in_o  = carry[WIDTH-1];
        c_msb_out_o = carry[WIDTH];
    end

endmodule

// File: rtl/adsub_ovf.sv
module adsub_ovf (
    input  logic c_msb_in_i,
    input  logic c_msb_out_i,
    output logic ovf_o
);

    // Range is left exactly when the top stage's carries disagree
    always_comb ovf_o = c_msb_in_i ^ c_msb_out_i;

endmodule

// File: rtl/adder_subtractor.sv
module adder_subtractor #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             ovf
);

    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic             c_top_in;
    logic             c_top_out;

    adsub_operand #(.WIDTH(WIDTH)) u_operand (
        .b_i     (op_b),
        .sub_i   (sub_mode),
        .b_eff_o (b_eff),
        .cin_o   (cin)
    );

    adsub_ripple #(.WIDTH(WIDTH)) u_chain (
        .a_i         (op_a),
        .b_i         (b_eff),
        .cin_i       (cin),
        .sum_o       (result),
        .c_msb_in_o  (c_top_in),
        .c_msb_out_o (c_top_out)
    );

    adsub_ovf u_flag (
        .c_msb_in_i  (c_top_in),
        .c_msb_out_i (c_top_out),
        .ovf_o       (ovf)
    );

    always_comb carry_out = c_top_out;

endmodule

// File: rtl/adsub_checker.sv
module adsub_checker #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_mode,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             ovf
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH:0] add_full;
    logic [WIDTH:0] sub_full;
    logic           sign_b_eff;
    logic           range_left;

    always_comb begin
        add_full   = {1'b0, op_a} + {1'b0, op_b};
        sub_full   = {1'b0, op_a} + {1'b0, ~op_b} + {{WIDTH{1'b0}}, 1'b1};
        sign_b_eff = sub_mode ? ~op_b[TOP] : op_b[TOP];
        range_left = (op_a[TOP] == sign_b_eff) && (result[TOP] != op_a[TOP]);
    end

    always_comb begin
        if (!sub_mode) begin
            assert_add_result_R1: assert (result == add_full[WIDTH-1:0])
                else $error("R1 add result mismatch");
            assert_add_carry_R3: assert (carry_out == add_full[WIDTH])
                else $error("R3 add carry mismatch");
            // R7: opposite signs under addition cannot leave the range
            assert_no_overflow_R7: assert (!(op_a[TOP] != op_b[TOP]) || !ovf)
                else $error("R7 flag set on opposite-sign add");
        end else begin
            assert_sub_result_R2: assert (result == sub_full[WIDTH-1:0])
                else $error("R2 sub result mismatch");
            assert_sub_carry_R3: assert (carry_out == sub_full[WIDTH])
                else $error("R3 sub carry mismatch");
            // R8: equal signs under subtraction cannot leave the range
            assert_no_overflow_R8: assert (!(op_a[TOP] == op_b[TOP]) || !ovf)
                else $error("R8 flag set on equal-sign sub");
        end
        assert_flag_sign_R4: assert (ovf == range_left)
            else $error("R4 flag disagrees with operand and result signs");
    end

endmodule

bind adder_subtractor adsub_checker #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_mode  (sub_mode),
    .result    (result),
    .carry_out (carry_out),
    .ovf       (ovf)
);

// File: tb/sim_adder_subtractor.sv
module sim_adder_subtractor;

    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int MOD        = 1 << W;
    localparam int SMAX       = (1 << (W - 1)) - 1;
    localparam int SMIN       = -(1 << (W - 1));
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic [W-1:0] res;
        logic         cy;
        logic         v;
        string        tag_res;
        string        tag_cy;
        string        tag_v;
    } exp_item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_mode = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         ovf;

    int        checks   = 0;
    int        failures = 0;
    bit        done     = 1'b0;
    exp_item_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    adder_subtractor #(.WIDTH(W)) u0 (
        .op_a      (op_a),
        .op_b      (op_b),
        .sub_mode  (sub_mode),
        .result    (result),
        .carry_out (carry_out),
        .ovf       (ovf)
    );

    function automatic int to_signed(input int u);
        return (u > SMAX) ? u - MOD : u;
    endfunction

    // Driver: applies one operation and pushes its expected outcome
    task automatic drive(input int ua, input int ub, input bit m,
                         input string tr, input string tc, input string tv);
        exp_item_t it;
        int sa, sb, truev, ures;
        sa    = to_signed(ua);
        sb    = to_signed(ub);
        truev = m ? sa - sb : sa + sb;
        ures  = ((truev % MOD) + MOD) % MOD;
        it.res = ures[W-1:0];
        it.v   = (truev > SMAX) || (truev < SMIN);
        it.cy  = m ? (ua >= ub) : ((ua + ub) >= MOD);
        it.tag_res = tr;
        it.tag_cy  = tc;
        it.tag_v   = tv;
        @(posedge clk);
        op_a     = ua[W-1:0];
        op_b     = ub[W-1:0];
        sub_mode = m;
        sb_q.push_back(it);
    endtask

    // Monitor: pops expectations and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (result !== it.res) begin
                    failures++;
                    $display("FAIL %s a=%0d b=%0d m=%0b result=%b expected=%b",
                             it.tag_res, op_a, op_b, sub_mode, result, it.res);
                end
                checks++;
                if (carry_out !== it.cy) begin
                    failures++;
                    $display("FAIL %s a=%0d b=%0d m=%0b carry=%0b expected=%0b",
                             it.tag_cy, op_a, op_b, sub_mode, carry_out, it.cy);
                end
                checks++;
                if (ovf !== it.v) begin
                    failures++;
                    $display("FAIL %s a=%0d b=%0d m=%0b ovf=%0b expected=%0b",
                             it.tag_v, op_a, op_b, sub_mode, ovf, it.v);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state after reset: 0 + 0 gives zero, no carry, no flag (R1 R3 R4)
        drive(0, 0, 1'b0, "R1", "R3", "R4");
        // R5: 7 + 7 -> 1110, flag set
        drive(7, 7, 1'b0, "R5", "R3", "R5");
        // R6: -7 + -7 -> 0010, flag set
        drive(9, 9, 1'b0, "R6", "R3", "R6");
        // R7: 7 + (-8) -> 1111, flag clear
        drive(7, 8, 1'b0, "R7", "R3", "R7");
        // R8: -8 - 1 -> 0111 flag set; 0 - (-8) -> 1000 flag set; 5 - 3 clear
        drive(8, 1, 1'b1, "R8", "R3", "R8");
        drive(0, 8, 1'b1, "R8", "R3", "R8");
        drive(5, 3, 1'b1, "R8", "R3", "R8");
        // Full sweep in both modes (R1 R2 R3 R4)
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < MOD; a++) begin
                for (int b = 0; b < MOD; b++) begin
                    drive(a, b, m[0], (m == 0) ? "R1" : "R2", "R3", "R4");
                end
            end
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired with %0d items pending", sb_q.size());
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule